// File: doc/BRIEF.md
# MDIO Management Slave

This block is the device side of the two-wire serial management link used to configure an Ethernet physical-layer device. It runs entirely on the management clock (MDC) and samples the data line on each rising edge. A frame decoder hunts for the synchronisation run of ones and the start pattern, then gathers the opcode, the device address and the register address. For a write, it shifts in sixteen data bits and commits them to a local bank of 16-bit registers. For a read, it takes over the line for the second turnaround slot and the sixteen data slots, and then releases it.

The device address has four fixed upper bits and one low bit taken from a strap input, so two such devices can share one controller. A disable input shuts off both reads and writes, which leaves configuration to board straps. The register bank decodes 32 addresses. Only the lower `NUM_IMPL` addresses hold storage: the rest read as zero and discard writes. The line is modelled as a data input, a data output and an output enable, with the pad outside the block.

Top module: `mdsl_top`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive 1 bits followed by the start pattern 0,1. A frame that has fewer than 32 leading ones is ignored completely. A longer run of ones is accepted.
- R2: The two bits after the start pattern select the operation: 0,1 is a write and 1,0 is a read. The codes 0,0 and 1,1 cause the frame to be ignored.
- R3: The five device-address bits, sent most significant first, must equal {PHY_HI, addr_strap}, where PHY_HI defaults to 0000. On a mismatch nothing is written and mdio_oe stays low for the whole frame.
- R4: A write stores the sixteen data bits (D15 first) in the register selected by the five register-address bits. The register changes only at the edge that samples D0, and a later read returns the stored value.
- R5: On an accepted read, mdio_oe rises after the MDC edge that samples the first turnaround slot. mdio_out is 0 for one cycle, then carries D15 down to D0 for one cycle each, and mdio_oe falls after the edge that samples D0. The line is driven for exactly 17 cycles.
- R6: Register addresses at or above NUM_IMPL (default 24) read as 0x0000, and writes to them have no effect.
- R7: While access_off is 1, write frames leave the registers unchanged and read frames leave mdio_oe low. When access_off returns to 0, both work again.
- R8: During and after reset, mdio_oe is 0 and every implemented register reads 0x0000.
- R9: A start pattern of 0,0 after a valid preamble aborts the frame, and the decoder searches for a new preamble. The next well-formed frame is handled normally.
- R10: With addr_strap at 1, the block answers device address 00001 and ignores 00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mdio_in | input | 1 | Data line as seen at the pad (reads 1 when nobody drives it) |
| access_off | input | 1 | 1 blocks all reads and writes over the serial link |
| addr_strap | input | 1 | Low bit of the device address |
| mdio_out | output | 1 | Value driven onto the data line while mdio_oe is 1 |
| mdio_oe | output | 1 | Output enable for the data line; 0 means high impedance |

## Verification
Well-formed reads and writes carry data patterns with all ones, mixed bits and alternating nibbles. These patterns separate the bit order and the sixteen-bit alignment, and they show the turnaround zero apart from D15. Malformed frames each differ from a good frame in exactly one field: a short preamble, a 0,0 start, an illegal opcode, or a foreign device address. Each is followed by a read of the targeted register, which shows that no write slipped through. Reads are also repeated with the disable input set, with the strap flipped, and at unimplemented addresses. For every frame, the bench compares the exact cycles of the drive window against the window a correct decoder would open.

// File: rtl/mdsl_pkg.sv
package mdsl_pkg;
  localparam int REG_AW   = 5;   // register address bits
  localparam int PHY_AW   = 5;   // device address bits
  localparam int DATA_W   = 16;  // register width
  localparam int PRE_LEN  = 32;  // ones needed before start
  localparam int HDR_LEN  = 2 + PHY_AW + REG_AW;  // opcode + addresses

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef enum logic [2:0] {
    S_HUNT,
    S_START,
    S_HDR,
    S_TA1,
    S_TA2,
    S_DATA
  } mdsl_state_e;
endpackage

// File: rtl/mdsl_frame_ctl.sv
module mdsl_frame_ctl
  import mdsl_pkg::*;
#(
  parameter logic [PHY_AW-2:0] PHY_HI = '0
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_in,
  input  logic              access_off,
  input  logic              addr_strap,
  output logic [REG_AW-1:0] reg_addr,
  output logic              rd_load,
  output logic              rd_shift,
  output logic              rd_done,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(PRE_LEN + 1);

  mdsl_state_e          state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [HDR_LEN-2:0]   hdr_q, hdr_d;
  logic [DATA_W-2:0]    dsh_q, dsh_d;
  logic [REG_AW-1:0]    addr_q, addr_d;
  logic                 is_rd_q, is_rd_d;

  logic [HDR_LEN-1:0]   hdr_full;
  logic [1:0]           op_code;
  logic [PHY_AW-1:0]    phy_field;
  logic [REG_AW-1:0]    reg_field;
  logic                 phy_ok;
  logic                 op_ok;
  logic                 hdr_last;
  logic                 data_last;

  assign hdr_full  = {hdr_q, mdio_in};
  assign op_code   = hdr_full[HDR_LEN-1 -: 2];
  assign phy_field = hdr_full[REG_AW +: PHY_AW];
  assign reg_field = hdr_full[REG_AW-1:0];
  assign phy_ok    = (phy_field == {PHY_HI, addr_strap});
  assign op_ok     = (op_code == OP_WR) || (op_code == OP_RD);
  assign hdr_last  = (cnt_q == CNT_W'(HDR_LEN - 1));
  assign data_last = (cnt_q == CNT_W'(DATA_W - 1));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    hdr_d    = hdr_q;
    dsh_d    = dsh_q;
    addr_d   = addr_q;
    is_rd_d  = is_rd_q;
    rd_load  = 1'b0;
    rd_shift = 1'b0;
    rd_done  = 1'b0;
    wr_en    = 1'b0;
    case (state_q)
      S_HUNT: begin
        if (mdio_in) begin
          if (cnt_q != CNT_W'(PRE_LEN)) cnt_d = cnt_q + 1'b1;
        end else begin
          cnt_d = '0;
          if (cnt_q == CNT_W'(PRE_LEN)) state_d = S_START;
        end
      end
      S_START: begin
        cnt_d   = '0;
        state_d = mdio_in ? S_HDR : S_HUNT;
      end
      S_HDR: begin
        hdr_d = hdr_full[HDR_LEN-2:0];
        if (hdr_last) begin
          cnt_d = '0;
          if (op_ok && phy_ok && !access_off) begin
            state_d = S_TA1;
            is_rd_d = (op_code == OP_RD);
            addr_d  = reg_field;
          end else begin
            state_d = S_HUNT;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_TA1: begin
        state_d = S_TA2;
        rd_load = is_rd_q && !access_off;
      end
      S_TA2: begin
        state_d  = S_DATA;
        cnt_d    = '0;
        rd_shift = is_rd_q;
      end
      S_DATA: begin
        dsh_d = {dsh_q[DATA_W-3:0], mdio_in};
        if (data_last) begin
          state_d = S_HUNT;
          cnt_d   = '0;
          rd_done = is_rd_q;
          wr_en   = !is_rd_q && !access_off;
        end else begin
          cnt_d    = cnt_q + 1'b1;
          rd_shift = is_rd_q;
        end
      end
      default: begin
        state_d = S_HUNT;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
      hdr_q   <= '0;
      dsh_q   <= '0;
      addr_q  <= '0;
      is_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      dsh_q   <= dsh_d;
      addr_q  <= addr_d;
      is_rd_q <= is_rd_d;
    end
  end

  assign reg_addr = addr_q;
  assign wr_data  = {dsh_q, mdio_in};

  AST_SHORT_PREAMBLE: assert property (@(posedge mdc) disable iff (!rst_n)
    (state_q == S_HUNT && !mdio_in && cnt_q != CNT_W'(PRE_LEN)) |=> (state_q == S_HUNT)); // R1

  AST_BAD_START_ABORT: assert property (@(posedge mdc) disable iff (!rst_n)
    (state_q == S_START && !mdio_in) |=> (state_q == S_HUNT && cnt_q == '0)); // R9

  AST_FOREIGN_ADDR: assert property (@(posedge mdc) disable iff (!rst_n)
    (state_q == S_HDR && hdr_last && !phy_ok) |=> (state_q == S_HUNT)); // R3

  AST_OFF_NO_ACCESS: assert property (@(posedge mdc) disable iff (!rst_n)
    (state_q == S_HDR && access_off) |=> (state_q != S_TA1)); // R7
endmodule

// File: rtl/mdsl_regbank.sv
module mdsl_regbank
  import mdsl_pkg::*;
#(
  parameter int NUM_IMPL = 24
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FLAT_W = NUM_IMPL * DATA_W;

  logic [FLAT_W-1:0] flat;

  for (genvar g = 0; g < NUM_IMPL; g++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_q, word_d;

    assign hit    = wr_en && (wr_addr == REG_AW'(g));
    assign word_d = hit ? wr_data : word_q;

    always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign flat[g*DATA_W +: DATA_W] = word_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_IMPL; i++) begin
      if (rd_addr == REG_AW'(i)) rd_data = flat[i*DATA_W +: DATA_W];
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge mdc) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) < NUM_IMPL))
      |=> (rd_addr != $past(wr_addr) || rd_data == $past(wr_data))); // R4
endmodule

// File: rtl/mdsl_out_drv.sv
module mdsl_out_drv
  import mdsl_pkg::*;
(
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              rd_load,
  input  logic              rd_shift,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_word,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam int SH_W  = DATA_W + 1;         // turnaround zero + data
  localparam int RUN_W = $clog2(SH_W + 2);

  logic [SH_W-1:0] sh_q, sh_d;
  logic            oe_q, oe_d;

  always_comb begin
    sh_d = sh_q;
    oe_d = oe_q;
    if (rd_load) begin
      sh_d = {1'b0, rd_word};
      oe_d = 1'b1;
    end else if (rd_done) begin
      sh_d = '0;
      oe_d = 1'b0;
    end else if (rd_shift) begin
      sh_d = {sh_q[SH_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      oe_q <= oe_d;
    end
  end

  assign mdio_out = oe_q & sh_q[SH_W-1];
  assign mdio_oe  = oe_q;

  logic [RUN_W-1:0] oe_run_q;
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)                        oe_run_q <= '0;
    else if (!oe_q)                    oe_run_q <= '0;
    else if (oe_run_q != '1)           oe_run_q <= oe_run_q + 1'b1;
  end

  AST_TA_DRIVES_LOW: assert property (@(posedge mdc) disable iff (!rst_n)
    rd_load |=> (mdio_oe && !mdio_out)); // R5

  AST_DRIVE_SPAN: assert property (@(posedge mdc) disable iff (!rst_n)
    oe_run_q <= RUN_W'(SH_W)); // R5
endmodule

// File: rtl/mdsl_top.sv
module mdsl_top
  import mdsl_pkg::*;
#(
  parameter int                NUM_IMPL = 24,
  parameter logic [PHY_AW-2:0] PHY_HI   = '0
) (
  input  logic mdc,
  input  logic rst_n,
  input  logic mdio_in,
  input  logic access_off,
  input  logic addr_strap,
  output logic mdio_out,
  output logic mdio_oe
);
  logic [1:0]        rsync_q;
  logic              rst_s_n;
  logic [REG_AW-1:0] reg_addr;
  logic              rd_load, rd_shift, rd_done, wr_en;
  logic [DATA_W-1:0] wr_data, rd_word;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  mdsl_frame_ctl #(.PHY_HI(PHY_HI)) u_ctl (
    .mdc        (mdc),
    .rst_n      (rst_s_n),
    .mdio_in    (mdio_in),
    .access_off (access_off),
    .addr_strap (addr_strap),
    .reg_addr   (reg_addr),
    .rd_load    (rd_load),
    .rd_shift   (rd_shift),
    .rd_done    (rd_done),
    .wr_en      (wr_en),
    .wr_data    (wr_data)
  );

  mdsl_regbank #(.NUM_IMPL(NUM_IMPL)) u_bank (
    .mdc     (mdc),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en),
    .wr_addr (reg_addr),
    .wr_data (wr_data),
    .rd_addr (reg_addr),
    .rd_data (rd_word)
  );

  mdsl_out_drv u_drv (
    .mdc      (mdc),
    .rst_n    (rst_s_n),
    .rd_load  (rd_load),
    .rd_shift (rd_shift),
    .rd_done  (rd_done),
    .rd_word  (rd_word),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
  );

  AST_IDLE_IN_RESET: assert property (@(posedge mdc)
    (!rst_s_n) |-> !mdio_oe); // R8
endmodule

// File: tb/test_mdsl_top.sv
module test_mdsl_top;
  logic mdc;
  logic rst_n;
  logic mdio_in;
  logic access_off;
  logic addr_strap;
  logic mdio_out;
  logic mdio_oe;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] mdl [32];

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  mdsl_top i_mdsl_top (
    .mdc        (mdc),
    .rst_n      (rst_n),
    .mdio_in    (mdio_in),
    .access_off (access_off),
    .addr_strap (addr_strap),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe)
  );

  initial mdc = 1'b0;
  always #10 mdc = ~mdc;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic put_bit(input bit b);
    @(negedge mdc);
    mdio_in = b;
  endtask

  // Driver: sends one frame, records the expected read result, checks the drive window.
  task automatic frame(input int pre, input bit [1:0] st, input bit [1:0] op,
                       input bit [4:0] phy, input bit [4:0] rg,
                       input bit [15:0] wd, input string tag);
    bit acc;
    bit resp;
    bit exp_oe;
    bit b;
    int oe_err;
    exp_t e;
    acc  = (pre >= 32) && (st == 2'b01) && (phy == {4'b0000, addr_strap}) && !access_off;
    resp = acc && (op == 2'b10);
    if (acc && op == 2'b01 && rg < 5'd24) mdl[rg] = wd;
    if (resp) begin
      e.val = (rg < 5'd24) ? mdl[rg] : 16'h0000;
      e.tag = tag;
      exp_q.push_back(e);
    end
    put_bit(1'b0);
    repeat (pre) put_bit(1'b1);
    put_bit(st[1]);
    put_bit(st[0]);
    put_bit(op[1]);
    put_bit(op[0]);
    for (int i = 4; i >= 0; i--) put_bit(phy[i]);
    for (int i = 4; i >= 0; i--) put_bit(rg[i]);
    oe_err = 0;
    for (int j = 1; j <= 19; j++) begin
      if (op == 2'b10 || j == 19 || j == 1) b = 1'b1;
      else if (j == 2)                      b = 1'b0;
      else                                  b = wd[18 - j];
      put_bit(b);
      exp_oe = resp && (j >= 2) && (j <= 18);
      if (mdio_oe !== exp_oe && oe_err == 0) oe_err = j;
    end
    check(oe_err == 0, tag, "drive window, first wrong slot", oe_err, 0);
  endtask

  // Monitor: captures each driven read and compares with the scoreboard.
  initial begin
    forever begin
      @(negedge mdc);
      if (rst_n === 1'b1 && mdio_oe === 1'b1) begin
        logic        ta;
        logic [15:0] got;
        exp_t        e;
        ta  = mdio_out;
        got = '0;
        for (int i = 0; i < 16; i++) begin
          @(negedge mdc);
          got = {got[14:0], mdio_out};
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "read drive with no read expected", int'(got), 0);
        end else begin
          e = exp_q.pop_front();
          check(ta === 1'b0, e.tag, "turnaround bit", int'(ta), 0);
          check(got === e.val, e.tag, "read data", int'(got), int'(e.val));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge mdc);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    mdio_in    = 1'b1;
    access_off = 1'b0;
    addr_strap = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = 16'h0000;
    repeat (3) @(negedge mdc);
    check(mdio_oe === 1'b0, "R8", "oe during reset", int'(mdio_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge mdc);
    check(mdio_oe === 1'b0, "R8", "oe after reset", int'(mdio_oe), 0);

    // R8: reset contents
    frame(32, 2'b01, 2'b10, 5'd0, 5'd0,  16'h0, "R8");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd13, 16'h0, "R8");

    // R4 / R5: write then read back, several patterns
    frame(32, 2'b01, 2'b01, 5'd0, 5'd3,  16'hA5C3, "R4");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd3,  16'h0, "R4");
    frame(32, 2'b01, 2'b01, 5'd0, 5'd0,  16'hFFFF, "R4");
    frame(32, 2'b01, 2'b01, 5'd0, 5'd23, 16'h1234, "R4");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd0,  16'h0, "R5");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd23, 16'h0, "R5");

    // R1: longer preamble accepted
    frame(45, 2'b01, 2'b01, 5'd0, 5'd7,  16'h5A0F, "R1");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd7,  16'h0, "R1");

    // R6: unimplemented addresses
    frame(32, 2'b01, 2'b01, 5'd0, 5'd28, 16'hBEEF, "R6");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd28, 16'h0, "R6");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd31, 16'h0, "R6");

    // R2: illegal opcodes ignored
    frame(32, 2'b01, 2'b00, 5'd0, 5'd3, 16'h0000, "R2");
    frame(32, 2'b01, 2'b11, 5'd0, 5'd3, 16'h0000, "R2");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd3, 16'h0, "R2");

    // R3: foreign device address
    frame(32, 2'b01, 2'b01, 5'd2, 5'd3, 16'h1111, "R3");
    frame(32, 2'b01, 2'b10, 5'd2, 5'd3, 16'h0, "R3");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd3, 16'h0, "R3");

    // R1: short preamble ignored
    frame(20, 2'b01, 2'b01, 5'd0, 5'd3, 16'h2222, "R1");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd3, 16'h0, "R1");

    // R9: bad start pattern, then recovery
    frame(32, 2'b00, 2'b01, 5'd0, 5'd3, 16'h0000, "R9");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd3, 16'h0, "R9");
    frame(32, 2'b01, 2'b01, 5'd0, 5'd3, 16'h4444, "R9");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd3, 16'h0, "R9");

    // R7: access disabled
    access_off = 1'b1;
    frame(32, 2'b01, 2'b01, 5'd0, 5'd3, 16'h5555, "R7");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd3, 16'h0, "R7");
    access_off = 1'b0;
    frame(32, 2'b01, 2'b10, 5'd0, 5'd3, 16'h0, "R7");

    // R10: strap selects the other address
    addr_strap = 1'b1;
    frame(32, 2'b01, 2'b01, 5'd1, 5'd5, 16'h0F0F, "R10");
    frame(32, 2'b01, 2'b10, 5'd0, 5'd5, 16'h0, "R10");
    frame(32, 2'b01, 2'b01, 5'd0, 5'd5, 16'h9999, "R10");
    frame(32, 2'b01, 2'b10, 5'd1, 5'd5, 16'h0, "R10");

    repeat (4) put_bit(1'b1);
    check(exp_q.size() == 0, "R5", "reads expected but never driven", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule